// File: doc/BRIEF.md
# Coherent Wide Timestamp Counter

This block keeps a free-running timestamp that is wider than the 32-bit register bus used to read it. The counter advances by one on every cycle in which an external tick-enable pulse is present and counting has been switched on. It never raises an interrupt. Software sees it through two bus registers: a read-only word holding the lower bits and an upper register that holds the remaining top bits and a run bit.

The upper bits are not read live. Reading the lower word also copies the counter's top bits, as they stand in that cycle, into a snapshot register. The upper register returns that snapshot. A read of the low word followed by a read of the upper register therefore gives one consistent wide value, even if the counter carries into its top bits between the two reads. Writing the upper register with the run bit set starts counting, and writing it with the run bit clear freezes the counter at its current value.

Top module: `coherent_stamp_counter`

## Requirements
- R1: After a synchronous active-low reset, the counter, the run bit and the snapshot are all zero, so reads of both registers return zero.
- R2: A bus write to the upper register (offset 0x64) loads the run bit from write-data bit 8. All other write-data bits are ignored.
- R3: While the run bit is 1, the counter increments by exactly one at each clock edge where `tick_en` is high. It holds at edges where `tick_en` is low.
- R4: While the run bit is 0, the counter holds its value whatever `tick_en` does.
- R5: A read of the low register (offset 0x60) returns counter bits LO_W-1:0, zero-extended, on `rdata` in the same cycle as the read strobe.
- R6: A read of the low register copies counter bits CNT_W-1:LO_W into the snapshot at that clock edge. A read of the upper register returns the snapshot in bits HI_W-1:0, the run bit in bit 8, and zero elsewhere.
- R7: A read of the upper register leaves the snapshot unchanged.
- R8: When a tick and a low-register read fall in the same cycle, both the returned low word and the snapshot take the value from before the increment.
- R9: The counter wraps from all ones to zero.
- R10: Reads of any other offset return zero. Writes to the low register or to any other offset change neither the run bit nor the counter.
- R11: The snapshot changes only on a low-register read. It keeps its value while the counter keeps advancing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Counting pulse, one cycle per tick |
| bus_rd | input | 1 | Read strobe for the addressed register |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the strobe cycle, zero when idle |

## Verification
The bench runs a full-width instance and a narrow instance (12-bit counter, 8-bit low word) from the same stimulus. The narrow instance is needed because only it can reach carries into the upper bits and the wrap to zero within the run.

Directed sequences cover five cases:
- ticks while stopped, which separates R4 from R3;
- writes with every bit except the run bit set, which shows the ignored bits;
- a read of the low word in the same cycle as a tick, which separates pre-increment from post-increment capture;
- a low read just before a carry, followed by later upper reads, which separates a held snapshot from live upper bits;
- unmapped accesses.

Seeded random mixes of reads, writes, idle cycles and tick density then test the register decode and counting against a bench model.

// File: rtl/stamp_pkg.sv
// Package: shared defaults and the access-kind type for the timestamp block.
// Assumes: offsets are byte addresses compared over the full address width.
package stamp_pkg;

    // Default geometry of the counter and of the register bus.
    localparam int unsigned STAMP_CNT_W  = 40;
    localparam int unsigned STAMP_LO_W   = 32;
    localparam int unsigned STAMP_DATA_W = 32;
    localparam int unsigned STAMP_ADDR_W = 8;

    // Register offsets and the run-bit position inside the upper register.
    localparam int unsigned STAMP_LO_OFF = 'h60;
    localparam int unsigned STAMP_HI_OFF = 'h64;
    localparam int unsigned STAMP_RUN_BIT = 8;

    // Decoded access kind for one bus cycle.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_LOW   = 2'd1,
        ACC_HIGH  = 2'd2,
        ACC_OTHER = 2'd3
    } acc_kind_t;

endpackage

// File: rtl/stamp_core.sv
// Module: stamp_core
// Free-running up counter. Advances by one when run and tick are both high,
// wraps naturally at the top. Assumes tick is a one-cycle-per-tick enable
// already synchronous to clk.
module stamp_core #(
    parameter int unsigned CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] count_q;

    // Count on enabled ticks; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (run && tick)
            count_q <= count_q + 1'b1;
    end

    assign count = count_q;

endmodule

// File: rtl/stamp_snap.sv
// Module: stamp_snap
// Snapshot register for the counter's upper bits. Loads only when take is
// high and otherwise keeps its value. Assumes hi_in is the pre-edge counter
// slice, so a same-cycle tick never leaks into the snapshot.
module stamp_snap #(
    parameter int unsigned HI_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic [HI_W-1:0] hi_in,
    output logic [HI_W-1:0] snap
);

    logic [HI_W-1:0] snap_q;

    // Capture the upper slice on a low-word read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap_q <= '0;
        else if (take)
            snap_q <= hi_in;
    end

    assign snap = snap_q;

endmodule

// File: rtl/stamp_regs.sv
// Module: stamp_regs
// Register decode: classifies each bus cycle, holds the run bit, flags
// low-word reads to the snapshot, and forms read data combinationally.
// Assumes read and write strobes are single-cycle and offsets exact.
module stamp_regs
    import stamp_pkg::*;
#(
    parameter int unsigned CNT_W   = STAMP_CNT_W,
    parameter int unsigned LO_W    = STAMP_LO_W,
    parameter int unsigned DATA_W  = STAMP_DATA_W,
    parameter int unsigned ADDR_W  = STAMP_ADDR_W,
    parameter int unsigned LO_OFF  = STAMP_LO_OFF,
    parameter int unsigned HI_OFF  = STAMP_HI_OFF,
    parameter int unsigned RUN_BIT = STAMP_RUN_BIT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd,
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [CNT_W-1:0]      count,
    input  logic [CNT_W-LO_W-1:0] snap,
    output logic                  run,
    output logic                  take,
    output logic [DATA_W-1:0]     rdata
);

    localparam int unsigned HI_W = CNT_W - LO_W;
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_OFF);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_OFF);

    acc_kind_t       rd_kind;
    logic            run_q;
    logic [DATA_W-1:0] lo_word;
    logic [DATA_W-1:0] hi_word;
    logic            wdata_unused;

    // Only the run bit of the write data is consumed.
    assign wdata_unused = ^wdata;

    // Classify the read access for this cycle.
    always_comb begin
        if (!rd)
            rd_kind = ACC_IDLE;
        else if (addr == LO_A)
            rd_kind = ACC_LOW;
        else if (addr == HI_A)
            rd_kind = ACC_HIGH;
        else
            rd_kind = ACC_OTHER;
    end

    // Run bit: loaded only by writes to the upper register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else if (wr && addr == HI_A)
            run_q <= wdata[RUN_BIT];
    end

    // Zero-extend the live low slice of the counter.
    always_comb begin
        lo_word = '0;
        lo_word[LO_W-1:0] = count[LO_W-1:0];
    end

    // Upper register image: snapshot bits plus run bit.
    always_comb begin
        hi_word = '0;
        hi_word[HI_W-1:0] = snap;
        hi_word[RUN_BIT] = run_q;
    end

    // Read mux; idle and unmapped reads return zero.
    always_comb begin
        unique case (rd_kind)
            ACC_LOW:  rdata = lo_word;
            ACC_HIGH: rdata = hi_word;
            default:  rdata = '0;
        endcase
    end

    assign take = (rd_kind == ACC_LOW);
    assign run  = run_q;

endmodule

// File: rtl/coherent_stamp_counter.sv
// Module: coherent_stamp_counter (top)
// Wide free-running timestamp read through a narrow bus. A low-word read
// snapshots the upper bits so a low-then-high read pair is coherent.
// Assumes tick_en is synchronous and at most one pulse per clock.
module coherent_stamp_counter
    import stamp_pkg::*;
#(
    parameter int unsigned CNT_W   = STAMP_CNT_W,
    parameter int unsigned LO_W    = STAMP_LO_W,
    parameter int unsigned DATA_W  = STAMP_DATA_W,
    parameter int unsigned ADDR_W  = STAMP_ADDR_W,
    parameter int unsigned LO_OFF  = STAMP_LO_OFF,
    parameter int unsigned HI_OFF  = STAMP_HI_OFF,
    parameter int unsigned RUN_BIT = STAMP_RUN_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int unsigned HI_W = CNT_W - LO_W;

    logic [CNT_W-1:0] cnt_q;
    logic [HI_W-1:0]  snap_q;
    logic             en_q;
    logic             take;

    stamp_core #(.CNT_W(CNT_W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (en_q),
        .tick  (tick_en),
        .count (cnt_q)
    );

    stamp_snap #(.HI_W(HI_W)) u_snap (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .hi_in (cnt_q[CNT_W-1:LO_W]),
        .snap  (snap_q)
    );

    stamp_regs #(
        .CNT_W  (CNT_W),
        .LO_W   (LO_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .LO_OFF (LO_OFF),
        .HI_OFF (HI_OFF),
        .RUN_BIT(RUN_BIT)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (bus_rd),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .count (cnt_q),
        .snap  (snap_q),
        .run   (en_q),
        .take  (take),
        .rdata (bus_rdata)
    );

endmodule

// File: rtl/stamp_chk.sv
// Module: stamp_chk
// Assertion checker bound to the top; observes ports and internal state.
module stamp_chk #(
    parameter int unsigned CNT_W   = 40,
    parameter int unsigned LO_W    = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned LO_OFF  = 'h60,
    parameter int unsigned HI_OFF  = 'h64,
    parameter int unsigned RUN_BIT = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick_en,
    input logic                  bus_rd,
    input logic                  bus_wr,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic [DATA_W-1:0]     bus_rdata,
    input logic [CNT_W-1:0]      cnt_q,
    input logic                  en_q,
    input logic [CNT_W-LO_W-1:0] snap_q
);

    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_OFF);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_OFF);

    logic after_rst;

    // Marks the edge right after a reset edge.
    always_ff @(posedge clk) after_rst <= !rst_n;

    // R1
    always_ff @(posedge clk)
        if (after_rst)
            reset_clear_chk: assert (cnt_q == '0 && !en_q && snap_q == '0);

    // R2
    run_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == HI_A) |=> (en_q == $past(bus_wdata[RUN_BIT])));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && tick_en) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R4
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_q && tick_en) |=> $stable(cnt_q));

    // R5
    low_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == LO_A) |-> (bus_rdata == DATA_W'(cnt_q[LO_W-1:0])));

    // R8
    snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == LO_A) |=> (snap_q == $past(cnt_q[CNT_W-1:LO_W])));

    // R11
    snap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_addr == LO_A) |=> $stable(snap_q));

    // R9
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && tick_en && (&cnt_q)) |=> (cnt_q == '0));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd || (bus_addr != LO_A && bus_addr != HI_A)) |-> (bus_rdata == '0));

endmodule

bind coherent_stamp_counter stamp_chk #(
    .CNT_W  (CNT_W),
    .LO_W   (LO_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .LO_OFF (LO_OFF),
    .HI_OFF (HI_OFF),
    .RUN_BIT(RUN_BIT)
) u_stamp_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt_q     (cnt_q),
    .en_q      (en_q),
    .snap_q    (snap_q)
);

// File: tb/test_coherent_stamp_counter.sv
// Bench: a full-width instance and a narrow instance (12-bit count, 8-bit
// low word) share stimulus. Both are checked against bench models.
module test_coherent_stamp_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_w;
    logic [31:0] rdata_n;

    int vectors = 0;
    int fails = 0;
    string tag = "R1";

    // Models: wide and narrow counters, snapshots, shared run bit.
    logic [39:0] m_cnt_w = '0;
    logic [11:0] m_cnt_n = '0;
    logic [7:0]  m_snap_w = '0;
    logic [3:0]  m_snap_n = '0;
    logic        m_run = 1'b0;

    always #4 clk = ~clk;

    coherent_stamp_counter i_coherent_stamp_counter (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_w)
    );

    coherent_stamp_counter #(.CNT_W(12), .LO_W(8)) i_narrow (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_n)
    );

    // Expected read data for given model state.
    function automatic logic [31:0] exp_rd(input logic rd, input logic [7:0] a,
                                           input logic [31:0] lo, input logic [7:0] snap,
                                           input logic run);
        if (!rd) return 32'h0;
        if (a == 8'h60) return lo;
        if (a == 8'h64) return {23'h0, run, snap};
        return 32'h0;
    endfunction

    task automatic check(input string t, input string who,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", t, who, act, exp);
        end
    endtask

    // One bus cycle: drive, check read data, step the models at the edge.
    task automatic step(input logic rd, input logic wr, input logic [7:0] a,
                        input logic [31:0] wd, input logic tk);
        logic [31:0] ew, en;
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd; tick_en = tk;
        #1;
        ew = exp_rd(rd, a, m_cnt_w[31:0], m_snap_w, m_run);
        en = exp_rd(rd, a, {24'h0, m_cnt_n[7:0]}, {4'h0, m_snap_n}, m_run);
        if (rd) begin
            check(tag, "wide", rdata_w, ew);
            check(tag, "narrow", rdata_n, en);
        end
        @(posedge clk);
        if (rd && a == 8'h60) begin
            m_snap_w = m_cnt_w[39:32];
            m_snap_n = m_cnt_n[11:8];
        end
        if (m_run && tk) begin
            m_cnt_w = m_cnt_w + 1'b1;
            m_cnt_n = m_cnt_n + 1'b1;
        end
        if (wr && a == 8'h64) m_run = wd[8];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_rd = 0; bus_wr = 0; tick_en = 1;
        repeat (3) @(posedge clk);
        m_cnt_w = '0; m_cnt_n = '0; m_snap_w = '0; m_snap_n = '0; m_run = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset();

        // R1: reset state reads as zero.
        tag = "R1";
        step(1, 0, 8'h60, 0, 0);
        step(1, 0, 8'h64, 0, 0);

        // R4: ticks while stopped do not count.
        tag = "R4";
        repeat (5) step(0, 0, 0, 0, 1);
        step(1, 0, 8'h60, 0, 1);

        // R2: write with every bit but the run bit set leaves it clear.
        tag = "R2";
        step(0, 1, 8'h64, 32'hFFFF_FEFF, 0);
        step(1, 0, 8'h64, 0, 0);
        step(0, 1, 8'h64, 32'h0000_0100, 0);
        step(1, 0, 8'h64, 0, 0);

        // R3: ten ticks then gaps.
        tag = "R3";
        repeat (10) step(0, 0, 0, 0, 1);
        step(1, 0, 8'h60, 0, 0);
        repeat (4) step(0, 0, 0, 0, 0);
        step(1, 0, 8'h60, 0, 0);

        // R8: read low in the tick cycle returns pre-increment value.
        tag = "R8";
        step(1, 0, 8'h60, 0, 1);
        step(1, 0, 8'h60, 0, 0);

        // R10: writes to low / unmapped and unmapped reads.
        tag = "R10";
        step(0, 1, 8'h60, 32'h0, 0);
        step(0, 1, 8'h10, 32'h0, 0);
        step(1, 0, 8'h64, 0, 0);
        step(1, 0, 8'h10, 0, 0);
        step(1, 0, 8'h68, 0, 0);

        // R6, R7, R11: snapshot before a carry on the narrow instance.
        tag = "R6";
        while (m_cnt_n[7:0] != 8'hFE) step(0, 0, 0, 0, 1);
        step(1, 0, 8'h60, 0, 1);
        tag = "R11";
        repeat (3) step(0, 0, 0, 0, 1);
        step(1, 0, 8'h64, 0, 1);
        tag = "R7";
        step(1, 0, 8'h64, 0, 1);
        tag = "R6";
        step(1, 0, 8'h60, 0, 0);
        step(1, 0, 8'h64, 0, 0);

        // R9: narrow counter passes all ones.
        tag = "R9";
        while (m_cnt_n != 12'hFFE) step(0, 0, 0, 0, 1);
        step(1, 0, 8'h60, 0, 1);
        step(1, 0, 8'h60, 0, 1);
        step(1, 0, 8'h64, 0, 0);
        step(1, 0, 8'h60, 0, 0);
        step(1, 0, 8'h64, 0, 0);

        // R4: stop and confirm hold.
        tag = "R4";
        step(0, 1, 8'h64, 32'h0, 1);
        repeat (6) step(0, 0, 0, 0, 1);
        step(1, 0, 8'h60, 0, 1);

        // R1: reset in mid-run clears everything again.
        do_reset();
        tag = "R1";
        step(1, 0, 8'h60, 0, 0);
        step(1, 0, 8'h64, 0, 0);

        // Random mix (R2 R3 R5 R6 R10).
        for (int i = 0; i < 6000; i++) begin
            int op = $urandom_range(0, 9);
            logic tk = ($urandom_range(0, 3) != 0);
            if (op < 4)      begin tag = "R5";  step(1, 0, 8'h60, 0, tk); end
            else if (op < 6) begin tag = "R6";  step(1, 0, 8'h64, 0, tk); end
            else if (op == 6) begin tag = "R2"; step(0, 1, 8'h64, $urandom() | (($urandom_range(0,5) != 0) ? 32'h100 : 32'h0), tk); end
            else if (op == 7) begin tag = "R10"; step($urandom_range(0,1) == 1, 1'b0, 8'($urandom_range(0, 255) & 8'hF8) | 8'h01, 0, tk); end
            else              begin tag = "R3";  step(0, 0, 0, 0, tk); end
        end
        tag = "R5";
        step(1, 0, 8'h60, 0, 0);
        step(1, 0, 8'h64, 0, 0);

        summary();
    end

endmodule